// File: doc/BRIEF.md
# Page Load Collector with Inactivity Close

This block collects the data loads that follow a page-program command and hands a complete page to the array programming engine. Once the command is seen, the whole buffer is filled with the erased value FFh. The block then waits for the first load, and that load fixes the target page. Further loads are written into the buffer at their offset within the page. Each load is either a single byte or a 16-bit word, chosen by the mode captured with the command.

No command marks the end of the load phase. The block closes the phase by itself when no accepted load arrives within a fixed window after the previous one. The window is set in clock cycles from the clock frequency and a microsecond limit. The block then pulses a start signal and holds the page number and the full page image steady until the engine reports done. Bytes that were never loaded keep the erased value, so all loaded and unloaded bytes go to the array in one programming period.

Top module: `page_load_buffer`

## Requirements
- R1: While reset is applied and directly after it, `loading`, `programming` and `pg_start` are 0, `pg_addr` is 0 and every byte of `pg_data` is FFh.
- R2: `cmd_start` is accepted only while the block is idle. Acceptance sets every buffer byte to FFh, captures `word_mode` and raises `loading` from the next cycle. A `cmd_start` pulse while loading or programming has no effect.
- R3: In byte mode (`word_mode`=0 at the command), a load writes `ld_data[7:0]` to byte offset `ld_addr[6:0]`. Byte k of the page sits at `pg_data[8k+7:8k]`.
- R4: In word mode (`word_mode`=1 at the command), a load writes `ld_data[7:0]` to the even byte offset `{ld_addr[6:1],0}` and `ld_data[15:8]` to the odd byte just above it. `ld_addr[0]` is ignored.
- R5: The first load after a command sets the page to `ld_addr[ADDR_W-1:7]`, shown on `pg_addr`. A later load whose upper address bits differ from that page changes nothing and does not restart the window.
- R6: A load to an offset that was already written replaces the earlier value.
- R7: Let an accepted load be taken at clock edge k. If no other load is accepted at edges k+1 through k+T, where T = CLK_MHZ*WINDOW_US, then at edge k+T `loading` falls, `programming` rises and `pg_start` is high for exactly one cycle. A load taken at edge k+T or earlier keeps the phase open and restarts the window.
- R8: Every byte offset not loaded since the command reads FFh in `pg_data` during programming.
- R9: While programming, `pg_addr` and `pg_data` hold their values, and loads and `cmd_start` are ignored. `pg_done` returns the block to idle at the next edge.
- R10: After a command and before the first load, the block waits without any time limit and never starts programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Page-program command accepted by the command decoder |
| word_mode | input | 1 | 1 = 16-bit loads, 0 = byte loads; captured with `cmd_start` |
| ld_valid | input | 1 | One load write this cycle |
| ld_addr | input | ADDR_W (21) | Byte address of the load |
| ld_data | input | 16 | Load data; low byte only in byte mode |
| pg_done | input | 1 | Programming engine finished the page |
| loading | output | 1 | Command taken, load phase open |
| programming | output | 1 | Page handed over, waiting for `pg_done` |
| pg_start | output | 1 | One-cycle pulse that starts array programming |
| pg_addr | output | ADDR_W-7 (14) | Page number of the collected page |
| pg_data | output | PAGE_BYTES*8 (1024) | Page image, byte k at bits 8k+7:8k |

## Verification
The embedded properties assume the command decoder gives `cmd_start` and `ld_valid` as single-cycle strobes that are stable across the sampling edge. They also assume `pg_done` comes only after `pg_start`. The stimulus drives every input on the falling clock edge, holds each strobe for exactly one cycle, and raises `pg_done` only while `programming` is high. The load gaps are placed at T-1 and T cycles and beyond, so that both sides of the inactivity limit are reached. This includes a stray `cmd_start` and stray loads during loading and programming.

// File: rtl/plb_pkg.sv
package plb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LOAD  = 2'd2,
    ST_PROG  = 2'd3
  } plb_state_e;

  // Byte lanes touched by one load: lane 0 always, lane 1 only for words.
  function automatic logic [1:0] lane_mask(input logic wide);
    return wide ? 2'b11 : 2'b01;
  endfunction

endpackage

// File: rtl/plb_gap_timer.sv
module plb_gap_timer #(
  parameter int LIMIT = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic expire
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  // Expiry means the final idle cycle of the window has passed with no restart.
  assign expire = run && !clear && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear || expire)   cnt <= '0;
    else if (run)               cnt <= cnt + 1'b1;
    else                        cnt <= '0;
  end

  // R7: the gap count never passes the window length
  p_gap_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(LIMIT));

  // R7: a restart always brings the count back to zero
  p_gap_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/plb_page_store.sv
module plb_page_store #(
  parameter int PAGE_BYTES = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    preset,
  input  logic                    wr_en,
  input  logic [$clog2(PAGE_BYTES)-1:0] wr_off,
  input  logic [1:0]              wr_mask,
  input  logic [15:0]             wr_data,
  output logic [PAGE_BYTES*8-1:0] mem_flat
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [OFF_W-1:0] off_hi;
  assign off_hi = wr_off + OFF_W'(1);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic hit_lo, hit_hi;
    assign hit_lo = wr_en && wr_mask[0] && (wr_off == OFF_W'(g));
    assign hit_hi = wr_en && wr_mask[1] && (off_hi == OFF_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n || preset)  mem_flat[8*g +: 8] <= 8'hFF;
      else if (hit_lo)       mem_flat[8*g +: 8] <= wr_data[7:0];
      else if (hit_hi)       mem_flat[8*g +: 8] <= wr_data[15:8];
    end
  end

  // R2: a preset leaves the whole page erased
  p_preset_erased_r2: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (&mem_flat));

  // R9: with no write and no preset the image does not move
  p_image_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !preset) |=> $stable(mem_flat));

endmodule

// File: rtl/plb_ctrl.sv
module plb_ctrl
  import plb_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int PAGE_BYTES = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_start,
  input  logic                          word_mode,
  input  logic                          ld_valid,
  input  logic [ADDR_W-1:0]             ld_addr,
  input  logic                          pg_done,
  input  logic                          expire,
  output logic                          timer_run,
  output logic                          timer_clear,
  output logic                          preset,
  output logic                          wr_en,
  output logic [$clog2(PAGE_BYTES)-1:0] wr_off,
  output logic [1:0]                    wr_mask,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_q,
  output logic                          start_q,
  output logic                          loading,
  output logic                          programming
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a,
                                              input logic wide);
    return wide ? {a[OFF_W-1:1], 1'b0} : a[OFF_W-1:0];
  endfunction

  plb_state_e state, state_nx;
  logic       wide_q;

  // Named events used by the datapath and by the properties
  logic ev_cmd_take, ev_first_ld, ev_more_ld, ev_ld_take, ev_expire;

  assign ev_cmd_take = (state == ST_IDLE)  && cmd_start;
  assign ev_first_ld = (state == ST_ARMED) && ld_valid;
  assign ev_more_ld  = (state == ST_LOAD)  && ld_valid && (page_of(ld_addr) == page_q);
  assign ev_ld_take  = ev_first_ld || ev_more_ld;
  assign ev_expire   = (state == ST_LOAD)  && expire;

  assign timer_run   = (state == ST_LOAD);
  assign timer_clear = ev_ld_take;
  assign preset      = ev_cmd_take;
  assign wr_en       = ev_ld_take;
  assign wr_off      = off_of(ld_addr, wide_q);
  assign wr_mask     = lane_mask(wide_q);
  assign loading     = (state == ST_ARMED) || (state == ST_LOAD);
  assign programming = (state == ST_PROG);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (cmd_start)   state_nx = ST_ARMED;
      ST_ARMED: if (ld_valid)    state_nx = ST_LOAD;
      ST_LOAD:  if (ev_expire)   state_nx = ST_PROG;
      ST_PROG:  if (pg_done)     state_nx = ST_IDLE;
      default:                   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wide_q  <= 1'b0;
      page_q  <= '0;
      start_q <= 1'b0;
    end else begin
      state   <= state_nx;
      start_q <= ev_expire;
      if (ev_cmd_take) wide_q <= word_mode;
      if (ev_first_ld) page_q <= page_of(ld_addr);
    end
  end

  // R7: the start strobe lasts a single cycle
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R7: the start strobe appears exactly when programming begins
  p_start_with_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(programming) |-> start_q);

  // R5: once loading, the page number is fixed
  p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |=> $stable(page_q));

  // R9: programming holds until done, whatever else arrives
  p_prog_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (programming && !pg_done) |=> programming);

  // R2: a command during the load phase does not reopen it
  p_cmd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && cmd_start) |-> !preset);

  // R10: with no load, the armed state never times out
  p_armed_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !ld_valid) |=> (state == ST_ARMED));

endmodule

// File: rtl/page_load_buffer.sv
module page_load_buffer #(
  parameter int ADDR_W     = 21,
  parameter int PAGE_BYTES = 128,
  parameter int CLK_MHZ    = 250,
  parameter int WINDOW_US  = 30
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cmd_start,
  input  logic                                 word_mode,
  input  logic                                 ld_valid,
  input  logic [ADDR_W-1:0]                    ld_addr,
  input  logic [15:0]                          ld_data,
  input  logic                                 pg_done,
  output logic                                 loading,
  output logic                                 programming,
  output logic                                 pg_start,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pg_addr,
  output logic [PAGE_BYTES*8-1:0]              pg_data
);
  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int GAP_CYCS = CLK_MHZ * WINDOW_US;

  logic             timer_run, timer_clear, expire;
  logic             preset, wr_en;
  logic [OFF_W-1:0] wr_off;
  logic [1:0]       wr_mask;

  plb_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .word_mode   (word_mode),
    .ld_valid    (ld_valid),
    .ld_addr     (ld_addr),
    .pg_done     (pg_done),
    .expire      (expire),
    .timer_run   (timer_run),
    .timer_clear (timer_clear),
    .preset      (preset),
    .wr_en       (wr_en),
    .wr_off      (wr_off),
    .wr_mask     (wr_mask),
    .page_q      (pg_addr),
    .start_q     (pg_start),
    .loading     (loading),
    .programming (programming)
  );

  plb_gap_timer #(.LIMIT(GAP_CYCS)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .clear  (timer_clear),
    .expire (expire)
  );

  plb_page_store #(.PAGE_BYTES(PAGE_BYTES)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset   (preset),
    .wr_en    (wr_en),
    .wr_off   (wr_off),
    .wr_mask  (wr_mask),
    .wr_data  (ld_data),
    .mem_flat (pg_data)
  );

  // R9: the handed-over page stays put until the engine finishes
  p_handover_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (programming && !pg_done) |=> ($stable(pg_data) && $stable(pg_addr)));

  // R2: loading and programming never overlap
  p_phase_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(loading && programming));

endmodule

// File: tb/page_load_buffer_tb_top.sv
module page_load_buffer_tb_top;
  localparam int AW   = 21;
  localparam int NB   = 128;
  localparam int GAP  = 250 * 30;   // window in 4 ns cycles

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_start = 1'b0, word_mode = 1'b0, ld_valid = 1'b0, pg_done = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [15:0]   ld_data = '0;
  logic          loading, programming, pg_start;
  logic [AW-8:0] pg_addr;
  logic [NB*8-1:0] pg_data;

  always #2 clk = ~clk;

  page_load_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .word_mode(word_mode),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data), .pg_done(pg_done),
    .loading(loading), .programming(programming), .pg_start(pg_start),
    .pg_addr(pg_addr), .pg_data(pg_data)
  );

  // ---------------- reference model ----------------
  int         m_phase;      // 0 idle, 1 waiting first load, 2 loading, 3 programming
  logic [7:0] m_buf [NB];
  int         m_page, m_gap;
  bit         m_wide, m_start;
  int         checks = 0, fails = 0, cyc = 0;
  string      cur_req = "R1";

  task automatic m_write(input int a, input int d);
    int off;
    if (m_wide) begin
      off = (a % NB) & ~1;
      m_buf[off]     = d[7:0];
      m_buf[off + 1] = d[15:8];
    end else begin
      m_buf[a % NB] = d[7:0];
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_page = 0; m_gap = 0; m_wide = 0; m_start = 0;
      foreach (m_buf[i]) m_buf[i] = 8'hFF;
    end else begin
      m_start = 0;
      case (m_phase)
        0: if (cmd_start) begin
             foreach (m_buf[i]) m_buf[i] = 8'hFF;
             m_wide = word_mode; m_phase = 1;
           end
        1: if (ld_valid) begin
             m_page = int'(ld_addr) / NB; m_gap = 0; m_phase = 2;
             m_write(int'(ld_addr), int'(ld_data));
           end
        2: if (ld_valid && int'(ld_addr) / NB == m_page) begin
             m_write(int'(ld_addr), int'(ld_data)); m_gap = 0;
           end else if (m_gap == GAP - 1) begin
             m_phase = 3; m_start = 1; m_gap = 0;
           end else m_gap++;
        default: if (pg_done) m_phase = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [NB*8-1:0] exp_img;
    for (int i = 0; i < NB; i++) exp_img[8*i +: 8] = m_buf[i];
    check(loading === (m_phase == 1 || m_phase == 2), "loading", 64'(loading),
          64'(m_phase == 1 || m_phase == 2));
    check(programming === (m_phase == 3), "programming", 64'(programming), 64'(m_phase == 3));
    check(pg_start === m_start, "pg_start", 64'(pg_start), 64'(m_start));
    check(pg_addr === (AW-7)'(m_page), "pg_addr", 64'(pg_addr), 64'(m_page));
    for (int i = 0; i < NB / 8; i++)
      check(pg_data[64*i +: 64] === exp_img[64*i +: 64], $sformatf("pg_data word %0d", i),
            pg_data[64*i +: 64], exp_img[64*i +: 64]);
  end

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    summary_and_end();
  end

  // ---------------- stimulus (all at falling edges) ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input bit wide);
    cmd_start = 1; word_mode = wide; @(negedge clk); cmd_start = 0; word_mode = 0;
  endtask

  task automatic load(input int a, input int d);
    ld_valid = 1; ld_addr = AW'(a); ld_data = 16'(d); @(negedge clk); ld_valid = 0;
  endtask

  task automatic done();
    pg_done = 1; @(negedge clk); pg_done = 0;
  endtask

  localparam int PA = 12'h234 * NB;
  localparam int PB = 14'h1ABC * NB;

  initial begin
    @(negedge clk); cur_req = "R1"; idle(3);
    rst_n = 1; idle(2);

    cur_req = "R2";  cmd(0); idle(2);
    cur_req = "R3";  load(PA + 0, 16'h11A1); load(PA + 5, 16'h22B2); load(PA + 127, 16'h33C3);
    cur_req = "R6";  load(PA + 5, 16'h44D4);
    cur_req = "R5";  load(PB + 9, 16'h5555); idle(3);
    cur_req = "R2";  cmd(1); idle(2);
    cur_req = "R7";  idle(GAP - 8); load(PA + 64, 16'h0077);   // exactly at the limit
    idle(GAP + 4);
    cur_req = "R9";  load(PA + 1, 16'h0099); cmd(0); idle(3);
    cur_req = "R8";  idle(2); done(); idle(2);

    cur_req = "R4";  cmd(1); load(PB + 16, 16'hBEEF); load(PB + 19, 16'h1122); load(PB + 126, 16'hA5C3);
    cur_req = "R6";  load(PB + 17, 16'hCAFE);
    cur_req = "R7";  idle(GAP); load(PB + 40, 16'h7777);        // one cycle late: ignored
    idle(4); cur_req = "R9"; done(); idle(3);

    cur_req = "R10"; cmd(0); idle(2 * GAP);
    load(PA + 3, 16'h0033); idle(GAP + 3); done(); idle(2);

    cur_req = "R2";  cmd(0); load(PB + 2, 16'h0002); cmd(1); load(PB + 6, 16'h0106);
    idle(GAP + 3); done(); idle(3);

    summary_and_end();
  end
endmodule